// File: doc/BRIEF.md
# CAN Mailbox Transmit Status Controller

This block keeps the transmit-side handshake for a bank of CAN message slots (sixteen by default). Host software sets a per-slot request flag. The block watches a bus-idle level from an abstract protocol engine. When the bus is idle and the channel is not already sending, it picks one eligible slot and marks it active. It also raises the channel-wide transmitter flag. The engine then reports the outcome as a one-cycle pulse: either arbitration was lost or the frame went out successfully.

After a loss, the slot drops back to waiting. Its request stays set, so the slot is tried again at the next idle period. After a success, the slot's sent flag is set and its active flag is cleared. If the interrupt enable is high, the block also does three things: it issues a one-cycle interrupt request, loads the number of the slot that transmitted, and sets a success flag.

Only hardware can set a sent flag. A slot whose sent flag is still 1 is never chosen again. To send from that slot again, software must clear both the sent and the request flags and then set the request once more.

Top module: `can_tx_slot_ctrl`

## Requirements
- R1: After reset, all request, active and sent flags are 0. The transmitter flag, the success flag, the slot-number field and the interrupt output are also 0.
- R2: A slot is eligible when its request is 1 and its sent flag is 0. Suppose the transmitter flag is 0, `bus_idle` is 1 and some slot is eligible. Then, one clock later, exactly that slot's active bit is 1 and the transmitter flag is 1.
- R3: When several slots are eligible at once, the slot with the lowest index is the one started.
- R4: A slot whose sent flag is 1 is never started, even while its request stays at 1.
- R5: Suppose `arb_lost` pulses while the transmitter flag is 1. One clock later, the active bit and the transmitter flag are 0, and the request and sent flags are unchanged. The slot starts again at the next idle period.
- R6: Suppose `tx_ok` pulses while the transmitter flag is 1 and `arb_lost` is 0. One clock later, the slot's sent flag is 1, its active bit is 0 and the transmitter flag is 0.
- R7: On a success with `int_en` = 1, `tx_irq` is 1 for exactly the one cycle after the pulse. In that same cycle, `last_slot` holds the slot index and `tx_succ` is 1. With `int_en` = 0, `tx_irq` stays 0 and `last_slot` and `tx_succ` keep their values.
- R8: `tx_succ` returns to 0 in the cycle after a new transmission starts.
- R9: A host write to slot j happens when `host_we[j]` = 1. It loads `req[j]` from `host_req_d[j]`. If `host_sent_d[j]` = 0 it clears `sent[j]`. If `host_sent_d[j]` = 1 it leaves `sent[j]` unchanged, so host writes can never set a sent flag.
- R10: When `arb_lost` and `tx_ok` pulse in the same cycle, the loss wins and the sent flag stays 0. Both pulses are ignored while the transmitter flag is 0.
- R11: While `bus_idle` is 0, no transmission starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | NUM_SLOTS | Per-slot host write enable |
| host_req_d | input | NUM_SLOTS | Request value written to each enabled slot |
| host_sent_d | input | NUM_SLOTS | Sent value written; only 0 has an effect |
| bus_idle | input | 1 | Engine reports the bus is idle |
| arb_lost | input | 1 | Engine pulse: arbitration lost |
| tx_ok | input | 1 | Engine pulse: frame sent successfully |
| int_en | input | 1 | Success-interrupt enable |
| slot_req | output | NUM_SLOTS | Per-slot request flags |
| slot_active | output | NUM_SLOTS | Per-slot active flags |
| slot_sent | output | NUM_SLOTS | Per-slot sent flags |
| tx_state | output | 1 | Channel is transmitting |
| tx_succ | output | 1 | Last transmission succeeded (with interrupt enabled) |
| last_slot | output | SLOT_W | Index of the slot that last succeeded |
| tx_irq | output | 1 | One-cycle successful-transmission interrupt |

## Verification
The assertions check five properties on every cycle:
- at most one slot is active, and the transmitter flag matches the active bits;
- a start only follows a cycle with the bus idle, and an arbitration loss always drops the transmitter flag;
- a sent flag can rise only for the slot that was active;
- an active slot never carries a sent flag;
- an interrupt is a single cycle long and always traces back to an enabled success.

Some behaviours can only be shown by the bench's scenarios, which drive chosen requests and engine pulses and compare against computed values:
- which slot wins when several request at once;
- retry after a loss;
- what the host write port does and does not change;
- the hold of `last_slot` and `tx_succ` when the interrupt is disabled.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;
   typedef enum logic {
      CH_IDLE    = 1'b0,
      CH_SENDING = 1'b1
   } ch_state_e;
endpackage

// File: rtl/can_tx_pick.sv
module can_tx_pick #(
   parameter int NUM_SLOTS = 16,
   localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
   input  logic [NUM_SLOTS-1:0] elig,
   output logic                 any,
   output logic [SLOT_W-1:0]    idx
);
   always_comb begin
      any = |elig;
      idx = '0;
      for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
         if (elig[i]) idx = SLOT_W'(i);
      end
   end
endmodule

// File: rtl/can_tx_slot_cell.sv
module can_tx_slot_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic we,
   input  logic req_d,
   input  logic sent_d,
   input  logic start_hit,
   input  logic lost_hit,
   input  logic ok_hit,
   output logic req,
   output logic active,
   output logic sent
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req    <= 1'b0;
         active <= 1'b0;
         sent   <= 1'b0;
      end else begin
         if (we) req <= req_d;
         if (ok_hit)            sent <= 1'b1;
         else if (we && !sent_d) sent <= 1'b0;
         if (start_hit)                active <= 1'b1;
         else if (lost_hit || ok_hit)  active <= 1'b0;
      end
   end
endmodule

// File: rtl/can_tx_status.sv
module can_tx_status
   import can_tx_pkg::*;
#(
   parameter int NUM_SLOTS = 16,
   localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_idle,
   input  logic              any_elig,
   input  logic [SLOT_W-1:0] sel_idx,
   input  logic              arb_lost,
   input  logic              tx_ok,
   input  logic              int_en,
   output logic              start,
   output logic              lost,
   output logic              done,
   output logic [SLOT_W-1:0] cur_idx,
   output logic              tx_state,
   output logic              tx_succ,
   output logic [SLOT_W-1:0] last_slot,
   output logic              tx_irq
);
   ch_state_e state;

   assign tx_state = (state == CH_SENDING);
   assign start    = (state == CH_IDLE) && bus_idle && any_elig;
   assign lost     = tx_state && arb_lost;
   assign done     = tx_state && tx_ok && !arb_lost;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= CH_IDLE;
         cur_idx   <= '0;
         tx_succ   <= 1'b0;
         last_slot <= '0;
         tx_irq    <= 1'b0;
      end else begin
         tx_irq <= done && int_en;
         if (start) begin
            state   <= CH_SENDING;
            cur_idx <= sel_idx;
            tx_succ <= 1'b0;
         end else if (lost || done) begin
            state <= CH_IDLE;
         end
         if (done && int_en) begin
            tx_succ   <= 1'b1;
            last_slot <= cur_idx;
         end
      end
   end
endmodule

// File: rtl/can_tx_slot_ctrl.sv
module can_tx_slot_ctrl #(
   parameter int NUM_SLOTS = 16,
   localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SLOTS-1:0] host_we,
   input  logic [NUM_SLOTS-1:0] host_req_d,
   input  logic [NUM_SLOTS-1:0] host_sent_d,
   input  logic                 bus_idle,
   input  logic                 arb_lost,
   input  logic                 tx_ok,
   input  logic                 int_en,
   output logic [NUM_SLOTS-1:0] slot_req,
   output logic [NUM_SLOTS-1:0] slot_active,
   output logic [NUM_SLOTS-1:0] slot_sent,
   output logic                 tx_state,
   output logic                 tx_succ,
   output logic [SLOT_W-1:0]    last_slot,
   output logic                 tx_irq
);
   if (NUM_SLOTS < 2 || NUM_SLOTS > 64) begin : g_bad_slots
      $error("can_tx_slot_ctrl: NUM_SLOTS must lie in 2..64");
   end

   logic [NUM_SLOTS-1:0] elig;
   logic                 any_elig;
   logic [SLOT_W-1:0]    sel_idx;
   logic [SLOT_W-1:0]    cur_idx;
   logic                 start, lost, done;

   assign elig = slot_req & ~slot_sent;

   can_tx_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
      .elig (elig),
      .any  (any_elig),
      .idx  (sel_idx)
   );

   can_tx_status #(.NUM_SLOTS(NUM_SLOTS)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_idle  (bus_idle),
      .any_elig  (any_elig),
      .sel_idx   (sel_idx),
      .arb_lost  (arb_lost),
      .tx_ok     (tx_ok),
      .int_en    (int_en),
      .start     (start),
      .lost      (lost),
      .done      (done),
      .cur_idx   (cur_idx),
      .tx_state  (tx_state),
      .tx_succ   (tx_succ),
      .last_slot (last_slot),
      .tx_irq    (tx_irq)
   );

   for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_slot
      can_tx_slot_cell u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .we        (host_we[j]),
         .req_d     (host_req_d[j]),
         .sent_d    (host_sent_d[j]),
         .start_hit (start && (sel_idx == SLOT_W'(j))),
         .lost_hit  (lost  && (cur_idx == SLOT_W'(j))),
         .ok_hit    (done  && (cur_idx == SLOT_W'(j))),
         .req       (slot_req[j]),
         .active    (slot_active[j]),
         .sent      (slot_sent[j])
      );
   end
endmodule

// File: rtl/can_tx_slot_ctrl_chk.sv
module can_tx_slot_ctrl_chk #(
   parameter int NUM_SLOTS = 16,
   localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_idle,
   input logic                 arb_lost,
   input logic                 tx_ok,
   input logic                 int_en,
   input logic [NUM_SLOTS-1:0] slot_active,
   input logic [NUM_SLOTS-1:0] slot_sent,
   input logic                 tx_state,
   input logic                 tx_irq,
   input logic [SLOT_W-1:0]    last_slot
);
   p_one_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_active));

   p_state_tracks_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_state == (slot_active != '0));

   p_start_needs_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_state) |-> $past(bus_idle));

   p_lost_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_state && arb_lost) |=> !tx_state);

   p_sent_from_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((slot_sent & ~$past(slot_sent) & ~$past(slot_active)) == '0));

   p_no_active_sent_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((slot_active & slot_sent) == '0));

   p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |=> !tx_irq);

   p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> $past(tx_state && tx_ok && !arb_lost && int_en));

   p_slot_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_irq |-> ($stable(last_slot) || $past(tx_state && tx_ok)));
endmodule

bind can_tx_slot_ctrl can_tx_slot_ctrl_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (.*);

// File: tb/can_tx_slot_ctrl_test.sv
module can_tx_slot_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int N = 16;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] host_we = '0, host_req_d = '0, host_sent_d = '1;
   logic         bus_idle = 1'b0, arb_lost = 1'b0, tx_ok = 1'b0, int_en = 1'b0;
   logic [N-1:0] slot_req, slot_active, slot_sent;
   logic         tx_state, tx_succ, tx_irq;
   logic [W-1:0] last_slot;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   can_tx_slot_ctrl #(.NUM_SLOTS(N)) uut (.*);

   task automatic step();
      @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic hwrite(input logic [N-1:0] we, input logic [N-1:0] rq, input logic [N-1:0] sd);
      host_we = we; host_req_d = rq; host_sent_d = sd;
      step();
      host_we = '0; host_sent_d = '1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [W-1:0] exp_last;
      logic         exp_succ;
      exp_last = '0; exp_succ = 1'b0;
      step(); step();
      rst_n = 1'b1;
      step();
      check("R1 req",    32'(slot_req), 0);
      check("R1 active", 32'(slot_active), 0);
      check("R1 sent",   32'(slot_sent), 0);
      check("R1 state",  32'(tx_state), 0);
      check("R1 succ",   32'(tx_succ), 0);
      check("R1 last",   32'(last_slot), 0);
      check("R1 irq",    32'(tx_irq), 0);

      // Single-slot sweep: start, success, interrupt, re-request blocked, clear.
      for (int j = 0; j < N; j++) begin
         logic [N-1:0] m;
         m = N'(1) << j;
         hwrite(m, '1, '1);
         check("R9 req load", 32'(slot_req), 32'(m));
         check("R9 sent write 1 ignored", 32'(slot_sent), 0);
         check("R11 no start while busy", 32'(tx_state), 0);
         bus_idle = 1'b1; step(); bus_idle = 1'b0;
         check("R2 active", 32'(slot_active), 32'(m));
         check("R2 state", 32'(tx_state), 1);
         if (j > 0) check("R8 succ cleared", 32'(tx_succ), 0);
         exp_succ = 1'b0;
         int_en = (j % 2 == 0);
         tx_ok = 1'b1; step(); tx_ok = 1'b0;
         if (int_en) begin exp_last = W'(j); exp_succ = 1'b1; end
         check("R6 sent", 32'(slot_sent), 32'(m));
         check("R6 active", 32'(slot_active), 0);
         check("R6 state", 32'(tx_state), 0);
         check("R7 irq", 32'(tx_irq), 32'(int_en));
         check("R7 last", 32'(last_slot), 32'(exp_last));
         check("R7 succ", 32'(tx_succ), 32'(exp_succ));
         step();
         check("R7 irq one cycle", 32'(tx_irq), 0);
         bus_idle = 1'b1; step(); bus_idle = 1'b0;
         check("R4 sent slot not restarted", 32'(tx_state), 0);
         hwrite(m, '0, '1);
         check("R9 sent kept on write 1", 32'(slot_sent), 32'(m));
         hwrite(m, '0, '0);
         check("R9 clear req", 32'(slot_req), 0);
         check("R9 clear sent", 32'(slot_sent), 0);
      end

      // Arbitration loss, retry, precedence and idle pulses.
      hwrite(N'(1) << 5, '1, '1);
      tx_ok = 1'b1; arb_lost = 1'b1; step(); tx_ok = 1'b0; arb_lost = 1'b0;
      check("R10 pulses ignored when idle", 32'(slot_sent), 0);
      check("R10 no irq when idle", 32'(tx_irq), 0);
      bus_idle = 1'b1; step(); bus_idle = 1'b0;
      check("R2 slot5 start", 32'(slot_active), 32'h20);
      arb_lost = 1'b1; step(); arb_lost = 1'b0;
      check("R5 active cleared", 32'(slot_active), 0);
      check("R5 state cleared", 32'(tx_state), 0);
      check("R5 req kept", 32'(slot_req), 32'h20);
      check("R5 sent kept", 32'(slot_sent), 0);
      bus_idle = 1'b1; step(); bus_idle = 1'b0;
      check("R5 retry", 32'(slot_active), 32'h20);
      arb_lost = 1'b1; tx_ok = 1'b1; step(); arb_lost = 1'b0; tx_ok = 1'b0;
      check("R10 loss wins sent", 32'(slot_sent), 0);
      check("R10 loss wins state", 32'(tx_state), 0);
      hwrite('1, '0, '0);

      // Priority sweep over contiguous request masks.
      for (int a = 0; a < N; a++) begin
         hwrite('1, N'(16'hFFFF << a), '1);
         step();
         check("R11 idle low no start", 32'(tx_state), 0);
         bus_idle = 1'b1; step(); bus_idle = 1'b0;
         check("R3 lowest selected", 32'(slot_active), 32'(N'(1) << a));
         arb_lost = 1'b1; step(); arb_lost = 1'b0;
         hwrite('1, '0, '0);
      end

      // Sent slot skipped: slot 2 sent, request 2 and 9, expect 9.
      int_en = 1'b0;
      hwrite(N'(1) << 2, '1, '1);
      bus_idle = 1'b1; step(); bus_idle = 1'b0;
      tx_ok = 1'b1; step(); tx_ok = 1'b0;
      hwrite(N'(1) << 9, '1, '1);
      bus_idle = 1'b1; step(); bus_idle = 1'b0;
      check("R4 skip sent slot", 32'(slot_active), 32'h200);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule